// File: doc/BRIEF.md
# Root Hub Port Ownership Router

This block sits between the downstream ports of a USB root hub and the three host controller cores that share them. One high-speed controller and two full-/low-speed companion controllers share the ports. Each port is routed either to its fixed companion or to the high-speed controller. Odd-numbered ports belong to companion 1 and even-numbered ports to companion 2. A per-port owner bit, written by the high-speed controller, moves a port to the high-speed core.

The router also gates port power. Each port's power enable follows only the request of the controller that owns that port. It sends each port's overcurrent indication only to that owner. A configured port count (2 to 5) switches the upper ports off entirely.

The router also combines the controllers' interrupt requests onto the chip-level lines. There are three separate interrupt lines, one per controller, and a merge setting folds all three onto the first line. The system-management requests share one output, and so do the wake requests. Every output is registered, so each output shows the inputs sampled at the previous rising clock edge.

Top module: `usb_port_router`

## Requirements
- R1: During synchronous reset, every port select reads 00 (no owner), every power enable and overcurrent status bit is 0, and the five active-low lines (three interrupts, system management, wake) are 1.
- R2: The effective port count is `port_count` clamped to the range 2..NUM_PORTS. A port whose 1-based number exceeds it has select 00, power 0 and no overcurrent status, whatever its other inputs.
- R3: An enabled port with owner bit 0 has select 01 (companion 1) if its number is odd and 10 (companion 2) if its number is even. Port p uses `port_sel[2p+1:2p]`, with p 0-based.
- R4: An enabled port with owner bit 1 has select 11 (high-speed controller).
- R5: A port's power enable equals the power request of its current owner for that port. Requests from the other two controllers have no effect. A change of owner bit therefore drops the old owner's power in the next cycle.
- R6: A low overcurrent input on an enabled port sets that port's bit in the status vector of its owner only (`oc_cmp1`, `oc_cmp2` or `oc_hs`). The status bits are active high. The other two vectors keep that bit at 0.
- R7: With `irq_merge` = 0, `int_a_n`, `int_b_n` and `int_c_n` are the inverses of `irq_req[0]` (companion 1), `irq_req[1]` (companion 2) and `irq_req[2]` (high-speed).
- R8: With `irq_merge` = 1, `int_a_n` is low when any `irq_req` bit is set, and `int_b_n` and `int_c_n` stay high.
- R9: `smi_n` is low exactly when at least one `smi_req` bit is set.
- R10: `pme_n` is low exactly when at least one `wake_req` bit is set.
- R11: Every output shows the inputs sampled at the previous rising clock edge (one register stage).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| port_count | input | CNT_W | Configured number of enabled ports |
| hs_owner | input | NUM_PORTS | Per-port owner bit, 1 = high-speed controller |
| oc_n | input | NUM_PORTS | Per-port overcurrent, active low |
| cmp1_pwr_req | input | NUM_PORTS | Companion 1 per-port power request |
| cmp2_pwr_req | input | NUM_PORTS | Companion 2 per-port power request |
| hs_pwr_req | input | NUM_PORTS | High-speed per-port power request |
| irq_req | input | 3 | Interrupt requests: bit0 companion 1, bit1 companion 2, bit2 high-speed |
| smi_req | input | 3 | System-management requests, same bit order |
| wake_req | input | 3 | Wake requests, same bit order |
| irq_merge | input | 1 | 1 folds all interrupts onto `int_a_n` |
| port_sel | output | 2*NUM_PORTS | Per-port owner code: 00 none, 01 companion 1, 10 companion 2, 11 high-speed |
| port_pwr | output | NUM_PORTS | Per-port power enable, active high |
| oc_cmp1 | output | NUM_PORTS | Overcurrent status seen by companion 1 |
| oc_cmp2 | output | NUM_PORTS | Overcurrent status seen by companion 2 |
| oc_hs | output | NUM_PORTS | Overcurrent status seen by the high-speed controller |
| int_a_n | output | 1 | Companion 1 interrupt, or merged interrupt |
| int_b_n | output | 1 | Companion 2 interrupt |
| int_c_n | output | 1 | High-speed interrupt |
| smi_n | output | 1 | Combined system-management interrupt |
| pme_n | output | 1 | Combined wake event |

## Verification
An error in the owner decode shows up one cycle after the offending input. The port's select code is wrong, and the power enable and overcurrent status follow the wrong controller. A clamp error on the port count shows up as power on an upper port that should be off, or a lower port left without an owner. The bench sweeps every configured count, including values outside 2..5, against every owner pattern. It varies the power, overcurrent and interrupt inputs at the same time. Because the block keeps no state beyond its single output register, any wrong value is visible in the cycle right after its inputs.

// File: rtl/usb_rt_pkg.sv
package usb_rt_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'b00,
    OWN_CMP1 = 2'b01,
    OWN_CMP2 = 2'b10,
    OWN_HS   = 2'b11
  } owner_e;

  localparam int unsigned N_CTRL    = 3;
  localparam int unsigned MIN_PORTS = 2;
endpackage

// File: rtl/rt_port_slice.sv
module rt_port_slice
  import usb_rt_pkg::*;
#(
  parameter owner_e COMPANION = OWN_CMP1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       hs_own,
  input  logic       oc_n,
  input  logic       cmp1_req,
  input  logic       cmp2_req,
  input  logic       hs_req,
  output logic [1:0] sel,
  output logic       pwr,
  output logic       oc1,
  output logic       oc2,
  output logic       och
);
  owner_e nxt_own, sel_q;
  logic   nxt_pwr, oc_hit;
  logic   pwr_q, oc1_q, oc2_q, och_q;

  always_comb begin
    if (!en)         nxt_own = OWN_NONE;
    else if (hs_own) nxt_own = OWN_HS;
    else             nxt_own = COMPANION;
    case (nxt_own)
      OWN_CMP1: nxt_pwr = cmp1_req;
      OWN_CMP2: nxt_pwr = cmp2_req;
      OWN_HS:   nxt_pwr = hs_req;
      default:  nxt_pwr = 1'b0;
    endcase
    oc_hit = en & ~oc_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= OWN_NONE;
      pwr_q <= 1'b0;
      oc1_q <= 1'b0;
      oc2_q <= 1'b0;
      och_q <= 1'b0;
    end else begin
      sel_q <= nxt_own;
      pwr_q <= nxt_pwr;
      oc1_q <= oc_hit && (nxt_own == OWN_CMP1);
      oc2_q <= oc_hit && (nxt_own == OWN_CMP2);
      och_q <= oc_hit && (nxt_own == OWN_HS);
    end
  end

  assign sel = sel_q;
  assign pwr = pwr_q;
  assign oc1 = oc1_q;
  assign oc2 = oc2_q;
  assign och = och_q;

  p_off_port_dark_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> (sel_q == OWN_NONE && !pwr_q && !oc1_q && !oc2_q && !och_q));

  p_hs_route_r4: assert property (@(posedge clk) disable iff (rst)
    (en && hs_own) |=> (sel_q == OWN_HS));

  p_pwr_follows_hs_r5: assert property (@(posedge clk) disable iff (rst)
    (en && hs_own) |=> (pwr_q == $past(hs_req)));

  p_oc_single_owner_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({oc1_q, oc2_q, och_q}));
endmodule

// File: rtl/rt_irq_combine.sv
module rt_irq_combine
  import usb_rt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [N_CTRL-1:0] irq_req,
  input  logic [N_CTRL-1:0] smi_req,
  input  logic [N_CTRL-1:0] wake_req,
  input  logic              merge,
  output logic              int_a_n,
  output logic              int_b_n,
  output logic              int_c_n,
  output logic              smi_n,
  output logic              pme_n
);
  logic a_q, b_q, c_q, s_q, w_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= 1'b1;
      b_q <= 1'b1;
      c_q <= 1'b1;
      s_q <= 1'b1;
      w_q <= 1'b1;
    end else begin
      a_q <= merge ? ~(|irq_req) : ~irq_req[0];
      b_q <= merge ? 1'b1 : ~irq_req[1];
      c_q <= merge ? 1'b1 : ~irq_req[2];
      s_q <= ~(|smi_req);
      w_q <= ~(|wake_req);
    end
  end

  assign int_a_n = a_q;
  assign int_b_n = b_q;
  assign int_c_n = c_q;
  assign smi_n   = s_q;
  assign pme_n   = w_q;

  p_merge_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    merge |=> (int_b_n && int_c_n));

  p_split_hs_line_r7: assert property (@(posedge clk) disable iff (rst)
    (!merge && irq_req[2]) |=> !int_c_n);

  p_smi_any_r9: assert property (@(posedge clk) disable iff (rst)
    (|smi_req) |=> !smi_n);

  p_pme_any_r10: assert property (@(posedge clk) disable iff (rst)
    (wake_req == '0) |=> pme_n);
endmodule

// File: rtl/usb_port_router.sv
module usb_port_router
  import usb_rt_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 5,
  parameter int unsigned CNT_W     = $clog2(NUM_PORTS + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [CNT_W-1:0]       port_count,
  input  logic [NUM_PORTS-1:0]   hs_owner,
  input  logic [NUM_PORTS-1:0]   oc_n,
  input  logic [NUM_PORTS-1:0]   cmp1_pwr_req,
  input  logic [NUM_PORTS-1:0]   cmp2_pwr_req,
  input  logic [NUM_PORTS-1:0]   hs_pwr_req,
  input  logic [2:0]             irq_req,
  input  logic [2:0]             smi_req,
  input  logic [2:0]             wake_req,
  input  logic                   irq_merge,
  output logic [2*NUM_PORTS-1:0] port_sel,
  output logic [NUM_PORTS-1:0]   port_pwr,
  output logic [NUM_PORTS-1:0]   oc_cmp1,
  output logic [NUM_PORTS-1:0]   oc_cmp2,
  output logic [NUM_PORTS-1:0]   oc_hs,
  output logic                   int_a_n,
  output logic                   int_b_n,
  output logic                   int_c_n,
  output logic                   smi_n,
  output logic                   pme_n
);
  localparam logic [CNT_W-1:0] CNT_LO = CNT_W'(MIN_PORTS);
  localparam logic [CNT_W-1:0] CNT_HI = CNT_W'(NUM_PORTS);

  logic [CNT_W-1:0]     eff_cnt;
  logic [NUM_PORTS-1:0] port_en;

  always_comb begin
    if (port_count < CNT_LO)      eff_cnt = CNT_LO;
    else if (port_count > CNT_HI) eff_cnt = CNT_HI;
    else                          eff_cnt = port_count;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam owner_e COMP = (p % 2 == 0) ? OWN_CMP1 : OWN_CMP2;
    assign port_en[p] = (CNT_W'(p + 1) <= eff_cnt);

    rt_port_slice #(.COMPANION(COMP)) slice_i (
      .clk      (clk),
      .rst      (rst),
      .en       (port_en[p]),
      .hs_own   (hs_owner[p]),
      .oc_n     (oc_n[p]),
      .cmp1_req (cmp1_pwr_req[p]),
      .cmp2_req (cmp2_pwr_req[p]),
      .hs_req   (hs_pwr_req[p]),
      .sel      (port_sel[2*p +: 2]),
      .pwr      (port_pwr[p]),
      .oc1      (oc_cmp1[p]),
      .oc2      (oc_cmp2[p]),
      .och      (oc_hs[p])
    );

    p_companion_route_r3: assert property (@(posedge clk) disable iff (rst)
      (port_en[p] && !hs_owner[p]) |=> (port_sel[2*p +: 2] == COMP));
  end

  rt_irq_combine irq_i (
    .clk      (clk),
    .rst      (rst),
    .irq_req  (irq_req),
    .smi_req  (smi_req),
    .wake_req (wake_req),
    .merge    (irq_merge),
    .int_a_n  (int_a_n),
    .int_b_n  (int_b_n),
    .int_c_n  (int_c_n),
    .smi_n    (smi_n),
    .pme_n    (pme_n)
  );

  p_min_ports_live_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (port_sel[1:0] != 2'b00 && port_sel[3:2] != 2'b00));
endmodule

// File: tb/usb_port_router_tb_top.sv
module usb_port_router_tb_top;
  localparam int NP = 5;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] port_count = '0;
  logic [NP-1:0] hs_owner = '0, oc_n = '1;
  logic [NP-1:0] cmp1_pwr_req = '0, cmp2_pwr_req = '0, hs_pwr_req = '0;
  logic [2:0]    irq_req = '0, smi_req = '0, wake_req = '0;
  logic          irq_merge = 1'b0;
  logic [2*NP-1:0] port_sel;
  logic [NP-1:0] port_pwr, oc_cmp1, oc_cmp2, oc_hs;
  logic          int_a_n, int_b_n, int_c_n, smi_n, pme_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  int unsigned rng = 32'h1234_5678;

  // expected outputs for the next sample
  int e_sel[NP], e_pwr[NP], e_o1[NP], e_o2[NP], e_oh[NP];
  int e_a, e_b, e_c, e_s, e_w;

  always #5 clk = ~clk;

  usb_port_router #(.NUM_PORTS(NP), .CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .port_count(port_count), .hs_owner(hs_owner),
    .oc_n(oc_n), .cmp1_pwr_req(cmp1_pwr_req), .cmp2_pwr_req(cmp2_pwr_req),
    .hs_pwr_req(hs_pwr_req), .irq_req(irq_req), .smi_req(smi_req),
    .wake_req(wake_req), .irq_merge(irq_merge), .port_sel(port_sel),
    .port_pwr(port_pwr), .oc_cmp1(oc_cmp1), .oc_cmp2(oc_cmp2), .oc_hs(oc_hs),
    .int_a_n(int_a_n), .int_b_n(int_b_n), .int_c_n(int_c_n),
    .smi_n(smi_n), .pme_n(pme_n)
  );

  function automatic int unsigned next_rand();
    rng ^= rng << 13;
    rng ^= rng >> 17;
    rng ^= rng << 5;
    return rng;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference for the inputs now on the pins
  task automatic model();
    int eff;
    eff = (port_count < 2) ? 2 : ((port_count > NP) ? NP : int'(port_count));
    for (int p = 0; p < NP; p++) begin
      bit en;
      bit oc;
      en = (p + 1) <= eff;
      if (!en) e_sel[p] = 0;
      else if (hs_owner[p]) e_sel[p] = 3;
      else e_sel[p] = ((p + 1) % 2 == 1) ? 1 : 2;
      case (e_sel[p])
        1: e_pwr[p] = cmp1_pwr_req[p];
        2: e_pwr[p] = cmp2_pwr_req[p];
        3: e_pwr[p] = hs_pwr_req[p];
        default: e_pwr[p] = 0;
      endcase
      oc = en && !oc_n[p];
      e_o1[p] = (oc && e_sel[p] == 1) ? 1 : 0;
      e_o2[p] = (oc && e_sel[p] == 2) ? 1 : 0;
      e_oh[p] = (oc && e_sel[p] == 3) ? 1 : 0;
    end
    if (irq_merge) begin
      e_a = (irq_req != 0) ? 0 : 1;
      e_b = 1;
      e_c = 1;
    end else begin
      e_a = irq_req[0] ? 0 : 1;
      e_b = irq_req[1] ? 0 : 1;
      e_c = irq_req[2] ? 0 : 1;
    end
    e_s = (smi_req != 0) ? 0 : 1;
    e_w = (wake_req != 0) ? 0 : 1;
  endtask

  task automatic compare_all();
    for (int p = 0; p < NP; p++) begin
      string rq;
      rq = (e_sel[p] == 0) ? "R2" : ((e_sel[p] == 3) ? "R4" : "R3");
      chk(rq, $sformatf("R11 port%0d sel", p + 1), int'(port_sel[2*p +: 2]), e_sel[p]);
      chk("R5", $sformatf("port%0d pwr", p + 1), int'(port_pwr[p]), e_pwr[p]);
      chk("R6", $sformatf("port%0d oc_cmp1", p + 1), int'(oc_cmp1[p]), e_o1[p]);
      chk("R6", $sformatf("port%0d oc_cmp2", p + 1), int'(oc_cmp2[p]), e_o2[p]);
      chk("R6", $sformatf("port%0d oc_hs", p + 1), int'(oc_hs[p]), e_oh[p]);
    end
    chk("R7/R8", "int_a_n", int'(int_a_n), e_a);
    chk("R7/R8", "int_b_n", int'(int_b_n), e_b);
    chk("R7/R8", "int_c_n", int'(int_c_n), e_c);
    chk("R9", "smi_n", int'(smi_n), e_s);
    chk("R10", "pme_n", int'(pme_n), e_w);
  endtask

  task automatic drive(input int cnt, input int own, input bit mrg);
    port_count   = CW'(cnt);
    hs_owner     = NP'(own);
    oc_n         = NP'(next_rand());
    cmp1_pwr_req = NP'(next_rand());
    cmp2_pwr_req = NP'(next_rand());
    hs_pwr_req   = NP'(next_rand());
    irq_req      = 3'(next_rand());
    smi_req      = 3'(next_rand() % 5);
    wake_req     = 3'(next_rand() % 6);
    irq_merge    = mrg;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_bad++;
      $display("FAIL R11 watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset with busy inputs
    drive(5, 31, 1'b0);
    irq_req = 3'b111; smi_req = 3'b111; wake_req = 3'b111; oc_n = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      chk("R1", $sformatf("reset port%0d sel", p + 1), int'(port_sel[2*p +: 2]), 0);
      chk("R1", $sformatf("reset port%0d pwr", p + 1), int'(port_pwr[p]), 0);
      chk("R1", $sformatf("reset port%0d oc", p + 1), int'({oc_cmp1[p], oc_cmp2[p], oc_hs[p]}), 0);
    end
    chk("R1", "reset irq lines", int'({int_a_n, int_b_n, int_c_n, smi_n, pme_n}), 31);

    rst = 1'b0;
    drive(2, 0, 1'b0);
    model();
    // sweep counts (including clamp cases) x owner patterns x merge
    for (int cnt = 0; cnt < 8; cnt++) begin
      for (int own = 0; own < 32; own++) begin
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          compare_all();
          drive(cnt, own, k == 1);
          model();
        end
      end
    end
    // R5: owner flip drops the previous owner's power next cycle
    @(negedge clk);
    compare_all();
    port_count = 3'd5; hs_owner = '0; cmp1_pwr_req = '1; cmp2_pwr_req = '1; hs_pwr_req = '0;
    model();
    @(negedge clk);
    compare_all();
    chk("R5", "all companion power on", int'(port_pwr), 31);
    hs_owner = '1;
    model();
    @(negedge clk);
    compare_all();
    chk("R5", "power dropped after handover", int'(port_pwr), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule